// File: doc/BRIEF.md
# TDM Output Serializer with Fractional Bit Advancement

This block turns parallel channel bytes into serial TDM output lines, most significant bit first. It can launch an output line earlier than the output frame boundary by a small programmable amount, so that delay added further downstream is offset. Timing comes from a fast tick input. One tick equals half of the normal advancement step. A frame-boundary pulse, given on a tick, marks position zero of each frame.

The block has several lanes, one for each stream group. Each lane has its own serial output, its own set of channel bytes, a 2-bit advancement setting and a flag that marks the top stream rate. At normal rates one advancement step is `STEP_TICKS` ticks, which is 7.6 ns when the tick is 3.8 ns. At the top rate the step is half that. A setting of 3 therefore leads the boundary by 22.8 ns at normal rates and by 11.4 ns at the top rate. Bit launch points come from the frame position plus the advancement, counted modulo the frame length. As a result, the first bit of a frame can go out during the last ticks of the previous frame.

Top module: `tdm_adv_serializer`

## Requirements
- R1: While reset is asserted, and after it is released until the first bit launch, every serial output is 0.
- R2: With advancement 0, bit 7 of channel 0 is driven on the serial output one clock after the tick that carries the frame-boundary pulse.
- R3: A lane sends its bytes MSB first, each bit held for `BIT_TICKS` ticks. Channel c of lane g is `chan_bytes[(g*CHANS+c)*8 +: 8]`, and channels go out in ascending order.
- R4: With the top-rate flag at 0, bit k of the frame launches at frame position (k*BIT_TICKS − adv*STEP_TICKS) modulo the frame length. The frame length is CHANS*8*BIT_TICKS ticks.
- R5: With the top-rate flag at 1, the advancement is adv*STEP_TICKS/2 ticks, and the launch rule of R4 is otherwise the same.
- R6: Each lane follows only its own advancement field `adv_sel[g*2 +: 2]` and its own flag `top_rate[g]`.
- R7: New advancement and rate-flag values take effect only on a tick that carries the frame-boundary pulse. The boundary tick itself is still computed with the previous values.
- R8: In a clock without a tick, no serial output changes.
- R9: With no frame pulse, the frame position wraps to 0 by itself after the last position of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing tick enable, half of a normal advancement step |
| frame_pulse | input | 1 | Output frame boundary, valid only together with tick |
| chan_bytes | input | NGRP*CHANS*8 | Channel bytes, lane-major then channel |
| adv_sel | input | NGRP*2 | Advancement setting, 2 bits per lane |
| top_rate | input | NGRP | Top-rate flag per lane, halves the step |
| sdo | output | NGRP | Serial data line per lane |

## Verification
Two events can fall on the same tick: latching a new advancement setting at the frame boundary, and evaluating bit launches with the previous setting. In addition, with advancement 0 the boundary tick also loads channel 0. The bench changes the setting in the middle of a frame for every combination of advancement and rate flag. It gives the two lanes opposite settings. It then compares every tick across the boundary with a position-based model in which the old setting governs the boundary tick and the new setting governs the ticks after it. Runs with gaps between ticks and a frame with no pulse check that the output holds still and that the position wraps by itself.

// File: rtl/tdm_adv_pkg.sv
package tdm_adv_pkg;

   // Rate class of a lane; the top class halves the advancement step.
   typedef enum logic {
      RATE_NORMAL = 1'b0,
      RATE_TOP    = 1'b1
   } rate_e;

   // Ticks needed to hold a full frame of serial bits.
   function automatic int unsigned frame_ticks(input int unsigned chans,
                                               input int unsigned bit_ticks);
      return chans * 8 * bit_ticks;
   endfunction

   // Largest lead in ticks that the advancement field can request.
   function automatic int unsigned max_lead(input int unsigned adv_w,
                                            input int unsigned step_ticks);
      return ((1 << adv_w) - 1) * step_ticks;
   endfunction

endpackage

// File: rtl/tdm_adv_frame_pos.sv
module tdm_adv_frame_pos #(
   parameter int unsigned FRAME_TICKS = 512,
   localparam int unsigned POS_W      = $clog2(FRAME_TICKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             frame_pulse,
   output logic [POS_W-1:0] pos_now,
   output logic [POS_W-1:0] pos_q,
   output logic             bound
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_TICKS - 1);

   // Position that applies to the current tick: a pulse forces zero,
   // otherwise the count advances and wraps on its own.
   always_comb begin
      if (frame_pulse) begin
         pos_now = '0;
      end else if (pos_q == LAST_POS) begin
         pos_now = '0;
      end else begin
         pos_now = pos_q + POS_W'(1);
      end
   end

   assign bound = tick & frame_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= LAST_POS;
      end else if (tick) begin
         pos_q <= pos_now;
      end
   end

endmodule

// File: rtl/tdm_adv_launch.sv
module tdm_adv_launch #(
   parameter int unsigned CHANS      = 32,
   parameter int unsigned BIT_TICKS  = 8,
   parameter int unsigned STEP_TICKS = 2,
   parameter int unsigned ADV_W      = 2,
   localparam int unsigned FRAME_BITS  = CHANS * 8,
   localparam int unsigned FRAME_TICKS = FRAME_BITS * BIT_TICKS,
   localparam int unsigned POS_W       = $clog2(FRAME_TICKS),
   localparam int unsigned BIDX_W      = $clog2(FRAME_BITS),
   localparam int unsigned CH_W        = BIDX_W - 3
) (
   input  logic [POS_W-1:0] pos_now,
   input  logic [ADV_W-1:0] adv_q,
   input  logic             top_q,
   output logic             launch,
   output logic             ch_start,
   output logic [CH_W-1:0]  ch_idx
);

   localparam logic [POS_W:0] STEP_NORM = (POS_W+1)'(STEP_TICKS);
   localparam logic [POS_W:0] STEP_TOP  = (POS_W+1)'(STEP_TICKS / 2);
   localparam logic [POS_W:0] FRAME_L   = (POS_W+1)'(FRAME_TICKS);

   logic [POS_W:0]    lead_t;
   logic [POS_W:0]    sum_t;
   logic [POS_W-1:0]  spos;
   logic [BIDX_W-1:0] bidx;

   // Lead in ticks: the step halves for a top-rate lane.
   always_comb begin
      if (top_q) begin
         lead_t = (POS_W+1)'(adv_q) * STEP_TOP;
      end else begin
         lead_t = (POS_W+1)'(adv_q) * STEP_NORM;
      end
      sum_t = {1'b0, pos_now} + lead_t;
      spos  = POS_W'((sum_t >= FRAME_L) ? (sum_t - FRAME_L) : sum_t);
   end

   // Bit decode: slicing for a power-of-two bit period, division otherwise.
   localparam int unsigned BT_W = $clog2(BIT_TICKS);
   generate
      if ((1 << BT_W) == BIT_TICKS) begin : g_pow2
         assign launch = (spos[BT_W-1:0] == '0);
         assign bidx   = spos[POS_W-1:BT_W];
      end else begin : g_div
         localparam logic [POS_W-1:0] BT_L = POS_W'(BIT_TICKS);
         assign launch = ((spos % BT_L) == '0);
         assign bidx   = BIDX_W'(spos / BT_L);
      end
   endgenerate

   assign ch_start = (bidx[2:0] == 3'd0);
   assign ch_idx   = bidx[BIDX_W-1:3];

endmodule

// File: rtl/tdm_adv_lane.sv
module tdm_adv_lane
   import tdm_adv_pkg::*;
#(
   parameter int unsigned CHANS      = 32,
   parameter int unsigned BIT_TICKS  = 8,
   parameter int unsigned STEP_TICKS = 2,
   parameter int unsigned ADV_W      = 2,
   localparam int unsigned FRAME_TICKS = frame_ticks(CHANS, BIT_TICKS),
   localparam int unsigned POS_W       = $clog2(FRAME_TICKS),
   localparam int unsigned CH_W        = $clog2(CHANS * 8) - 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               bound,
   input  logic [POS_W-1:0]   pos_now,
   input  logic [CHANS*8-1:0] bytes_in,
   input  logic [ADV_W-1:0]   adv_in,
   input  logic               top_in,
   output logic               sdo,
   output logic [ADV_W-1:0]   adv_q,
   output logic               top_q
);

   rate_e            rate_q;
   logic             launch;
   logic             ch_start;
   logic [CH_W-1:0]  ch_idx;
   logic [7:0]       cur_byte;
   logic [7:0]       shreg;

   assign top_q = (rate_q == RATE_TOP);

   tdm_adv_launch #(
      .CHANS      (CHANS),
      .BIT_TICKS  (BIT_TICKS),
      .STEP_TICKS (STEP_TICKS),
      .ADV_W      (ADV_W)
   ) u_launch (
      .pos_now  (pos_now),
      .adv_q    (adv_q),
      .top_q    (top_q),
      .launch   (launch),
      .ch_start (ch_start),
      .ch_idx   (ch_idx)
   );

   assign cur_byte = bytes_in[int'(ch_idx)*8 +: 8];

   // Settings latch on the boundary tick; launch uses the values held before it.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adv_q  <= '0;
         rate_q <= RATE_NORMAL;
         shreg  <= '0;
         sdo    <= 1'b0;
      end else if (tick) begin
         if (bound) begin
            adv_q  <= adv_in;
            rate_q <= top_in ? RATE_TOP : RATE_NORMAL;
         end
         if (launch) begin
            if (ch_start) begin
               sdo   <= cur_byte[7];
               shreg <= {cur_byte[6:0], 1'b0};
            end else begin
               sdo   <= shreg[7];
               shreg <= {shreg[6:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/tdm_adv_serializer.sv
module tdm_adv_serializer
   import tdm_adv_pkg::*;
#(
   parameter int unsigned NGRP       = 4,
   parameter int unsigned CHANS      = 32,
   parameter int unsigned BIT_TICKS  = 8,
   parameter int unsigned STEP_TICKS = 2,
   parameter int unsigned ADV_W      = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     frame_pulse,
   input  logic [NGRP*CHANS*8-1:0]  chan_bytes,
   input  logic [NGRP*ADV_W-1:0]    adv_sel,
   input  logic [NGRP-1:0]          top_rate,
   output logic [NGRP-1:0]          sdo
);

   localparam int unsigned FRAME_TICKS = frame_ticks(CHANS, BIT_TICKS);
   localparam int unsigned POS_W       = $clog2(FRAME_TICKS);
   localparam int unsigned LANE_BITS   = CHANS * 8;

   // Elaboration-time parameter checks.
   if (NGRP < 1) begin : g_bad_ngrp
      $error("NGRP must be at least 1");
   end
   if (CHANS < 2) begin : g_bad_chans
      $error("CHANS must be at least 2");
   end
   if ((STEP_TICKS < 2) || ((STEP_TICKS % 2) != 0)) begin : g_bad_step
      $error("STEP_TICKS must be even and at least 2");
   end
   if (max_lead(ADV_W, STEP_TICKS) > BIT_TICKS) begin : g_bad_lead
      $error("largest advancement exceeds one bit period");
   end

   logic [POS_W-1:0]      pos_now;
   logic [POS_W-1:0]      pos_q;
   logic                  bound;
   logic [NGRP*ADV_W-1:0] adv_q_all;
   logic [NGRP-1:0]       top_q_all;
   logic [NGRP-1:0]       lead_msb;

   tdm_adv_frame_pos #(
      .FRAME_TICKS (FRAME_TICKS)
   ) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .frame_pulse (frame_pulse),
      .pos_now     (pos_now),
      .pos_q       (pos_q),
      .bound       (bound)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_lane
      assign lead_msb[g] = chan_bytes[g*LANE_BITS + 7];

      tdm_adv_lane #(
         .CHANS      (CHANS),
         .BIT_TICKS  (BIT_TICKS),
         .STEP_TICKS (STEP_TICKS),
         .ADV_W      (ADV_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .bound    (bound),
         .pos_now  (pos_now),
         .bytes_in (chan_bytes[g*LANE_BITS +: LANE_BITS]),
         .adv_in   (adv_sel[g*ADV_W +: ADV_W]),
         .top_in   (top_rate[g]),
         .sdo      (sdo[g]),
         .adv_q    (adv_q_all[g*ADV_W +: ADV_W]),
         .top_q    (top_q_all[g])
      );
   end

endmodule

// File: rtl/tdm_adv_serializer_chk.sv
module tdm_adv_serializer_chk #(
   parameter int unsigned NGRP        = 4,
   parameter int unsigned ADV_W       = 2,
   parameter int unsigned FRAME_TICKS = 512,
   localparam int unsigned POS_W      = $clog2(FRAME_TICKS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tick,
   input logic                  frame_pulse,
   input logic [NGRP-1:0]       sdo,
   input logic [NGRP*ADV_W-1:0] adv_q_all,
   input logic [NGRP-1:0]       top_q_all,
   input logic [NGRP-1:0]       lead_msb,
   input logic [POS_W-1:0]      pos_q
);

   // R8
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(sdo));

   // R7
   setting_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && frame_pulse) |=> ($stable(adv_q_all) && $stable(top_q_all)));

   // R9
   pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !frame_pulse && (pos_q == POS_W'(FRAME_TICKS - 1))) |=> (pos_q == '0));

   for (genvar g = 0; g < NGRP; g++) begin : g_lane_chk
      // R2
      zero_adv_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tick && frame_pulse && (adv_q_all[g*ADV_W +: ADV_W] == '0))
            |=> (sdo[g] == $past(lead_msb[g])));
   end

endmodule

bind tdm_adv_serializer tdm_adv_serializer_chk #(
   .NGRP        (NGRP),
   .ADV_W       (ADV_W),
   .FRAME_TICKS (FRAME_TICKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .frame_pulse (frame_pulse),
   .sdo         (sdo),
   .adv_q_all   (adv_q_all),
   .top_q_all   (top_q_all),
   .lead_msb    (lead_msb),
   .pos_q       (pos_q)
);

// File: tb/tdm_adv_serializer_test.sv
module tdm_adv_serializer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NGRP  = 2;
   localparam int CHANS = 2;
   localparam int BT    = 8;
   localparam int STEP  = 2;
   localparam int FRAME = CHANS * 8 * BT;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    tick = 1'b0;
   logic                    frame_pulse = 1'b0;
   logic [NGRP*CHANS*8-1:0] chan_bytes = '0;
   logic [NGRP*2-1:0]       adv_sel = '0;
   logic [NGRP-1:0]         top_rate = '0;
   logic [NGRP-1:0]         sdo;

   int    chk_cnt = 0;
   int    err_cnt = 0;
   int    bpos = FRAME - 1;
   int    a_lat [NGRP];
   int    h_lat [NGRP];
   logic  expv [NGRP];
   bit    chk_en = 0;
   bit    pending = 0;
   bit    drop_pulse = 0;
   string ovr = "";

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_adv_serializer #(
      .NGRP       (NGRP),
      .CHANS      (CHANS),
      .BIT_TICKS  (BT),
      .STEP_TICKS (STEP),
      .ADV_W      (2)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .frame_pulse (frame_pulse),
      .chan_bytes  (chan_bytes),
      .adv_sel     (adv_sel),
      .top_rate    (top_rate),
      .sdo         (sdo)
   );

   function automatic int lead_of(input int g);
      return h_lat[g] ? a_lat[g] * (STEP / 2) : a_lat[g] * STEP;
   endfunction

   // Bit driven at frame position p: latest launch by the R4/R5 rule.
   function automatic logic exp_bit(input int g, input int p);
      int s = (p + lead_of(g)) % FRAME;
      int k = s / BT;
      return chan_bytes[g*CHANS*8 + (k/8)*8 + 7 - (k%8)];
   endfunction

   function automatic string tag_of(input int g);
      if (ovr != "") return ovr;
      if (pending) return "R7";
      if (g == 1) return "R6";
      if (lead_of(g) == 0 && bpos < BT) return "R2";
      if (lead_of(g) == 0) return "R3";
      return h_lat[g] ? "R5" : "R4";
   endfunction

   task automatic check_bit(input string tag, input int g, input logic got, input logic exp);
      chk_cnt++;
      if (got !== exp) begin
         err_cnt++;
         $display("FAIL %s lane %0d pos %0d: got %0b expected %0b", tag, g, bpos, got, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, judge at the next falling edge.
   task automatic step(input logic tk, input logic fp);
      tick = tk;
      frame_pulse = fp;
      @(negedge clk);
      if (tk) begin
         bpos = fp ? 0 : (bpos + 1) % FRAME;
         for (int g = 0; g < NGRP; g++) expv[g] = exp_bit(g, bpos);
      end
      if (chk_en)
         for (int g = 0; g < NGRP; g++) check_bit(tag_of(g), g, sdo[g], expv[g]);
      if (tk && fp) begin
         for (int g = 0; g < NGRP; g++) begin
            a_lat[g] = int'(adv_sel[g*2 +: 2]);
            h_lat[g] = int'(top_rate[g]);
         end
         pending = 0;
      end
      tick = 1'b0;
      frame_pulse = 1'b0;
   endtask

   task automatic tick1();
      int nxt = (bpos + 1) % FRAME;
      step(1'b1, (nxt == 0) && !drop_pulse);
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) tick1();
   endtask

   task automatic run_until(input int p);
      tick1();
      while (bpos != p) tick1();
   endtask

   task automatic set_cfg(input int g, input int a, input int h);
      adv_sel[g*2 +: 2] = 2'(a);
      top_rate[g] = h[0];
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      err_cnt++;
      chk_cnt++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", chk_cnt, err_cnt);
      $finish;
   end

   initial begin
      for (int g = 0; g < NGRP; g++) begin
         a_lat[g] = 0;
         h_lat[g] = 0;
         expv[g] = 1'b0;
      end
      chan_bytes = {16'h29D7, 16'hB4E1};
      repeat (4) @(negedge clk);
      for (int g = 0; g < NGRP; g++) check_bit("R1", g, sdo[g], 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int g = 0; g < NGRP; g++) check_bit("R1", g, sdo[g], 1'b0);

      // Warm-up frame, then every tick is judged.
      run_ticks(FRAME);
      chk_en = 1;
      run_ticks(FRAME);

      // Full sweep of advancement and rate flag, lanes set oppositely, changed mid-frame.
      for (int a = 0; a < 4; a++) begin
         for (int h = 0; h < 2; h++) begin
            run_until(60);
            set_cfg(0, a, h);
            set_cfg(1, 3 - a, 1 - h);
            pending = 1;
            run_ticks(2 * FRAME);
         end
      end

      // Gaps between ticks: output holds.
      ovr = "R8";
      set_cfg(0, 3, 0);
      set_cfg(1, 1, 1);
      run_until(FRAME - 1);
      for (int i = 0; i < FRAME; i++) begin
         tick1();
         step(1'b0, 1'b0);
         step(1'b0, 1'b0);
      end

      // A missing frame pulse: the position wraps on its own.
      ovr = "R9";
      run_until(100);
      drop_pulse = 1;
      run_ticks(FRAME);
      drop_pulse = 0;

      // New channel data, one frame to refill, then judged again.
      ovr = "R3";
      chk_en = 0;
      run_until(60);
      chan_bytes = {16'hC01F, 16'h6E92};
      run_ticks(FRAME);
      chk_en = 1;
      run_ticks(FRAME);

      $display("Simulation finished: %0d checks, %0d errors", chk_cnt, err_cnt);
      $finish;
   end

endmodule